// File: doc/BRIEF.md
# Synchronous SRAM Capture Controller

This block stores a stream of byte-wide interval samples into an external asynchronous static RAM while acquisition runs. Afterwards, a host microcontroller reads the captured bytes back one at a time. All logic sits in one master clock domain. Every host command and every incoming sample is a single-cycle enable in that domain. No strobe is used as a clock.

An 18-bit address pointer selects the memory location. The host can clear the pointer, or load it one byte field at a time. The pointer advances by one after each stored sample and after each host read. When it rolls over from all ones to zero, a full flag is raised.

The block drives the memory's chip-select, write-enable and output-enable lines, the address and a split data bus. It also decides who owns the memory. While acquisition is active, host read requests are refused with a busy pulse and never reach the memory, so a capture in progress cannot be corrupted. Samples that arrive while the memory is full, or while a write is still in progress, are dropped. A dropped sample raises a sticky overflow flag.

Top module: `sram_capture_ctrl`

## Requirements
- R1: A host clear takes precedence over every other pointer command. One cycle later the pointer is 0 and both the full flag and the overflow flag are 0.
- R2: The three load strobes each write one field of the pointer from `host_din`:
  - the low strobe writes bits [7:0];
  - the mid strobe writes bits [15:8];
  - the upper strobe writes bits [17:16] from `host_din[1:0]` only.
  
  If several load strobes are high together, only the highest-priority one takes effect (low, then mid, then upper). Any load clears the full flag and the overflow flag.
- R3: A sample is accepted when `acq_active` and `smp_valid` are both high, the engine is idle and the memory is not full. An accepted sample is written at the current pointer. The pointer then becomes pointer+1, three edges after the strobe. A step from all ones to zero sets the full flag.
- R4: `empty` is high exactly when the pointer equals zero.
- R5: A write lasts two cycles, both with chip-select low and output-enable high:
  - in the first cycle, write-enable is low and the data bus is driven with the sample at the pointer address;
  - in the second cycle, write-enable is high and the address and data are unchanged.
- R6: A sample that arrives while the memory is full, or while the engine is busy, is not written. Such a sample sets the overflow flag, which stays set until a clear or a load. A sample strobe is ignored while `acq_active` is low.
- R7: A host read request is refused if `acq_active` is high or the engine is busy. A refused request gives a one-cycle `rd_busy` pulse in the next cycle. It causes no memory access and leaves the pointer unchanged.
- R8: A host read request accepted while idle with `acq_active` low runs a two-cycle memory read:
  - chip-select and output-enable are low, write-enable is high, and the bus is not driven;
  - the byte at the pointer is placed on `rd_data`, and `rd_valid` pulses in the cycle after the third edge;
  - the pointer advances by one, and a wrap sets the full flag.
- R9: After reset:
  - the pointer is 0, so `empty` is 1;
  - the full and overflow flags are 0;
  - all three memory control lines are high;
  - `rd_valid` and `rd_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_active | input | 1 | Acquisition mode; host reads refused while high |
| smp_valid | input | 1 | One-cycle sample strobe |
| smp_data | input | 8 | Sample byte |
| host_clr | input | 1 | Clear pointer, full and overflow |
| host_ld_lo | input | 1 | Load pointer bits [7:0] |
| host_ld_mid | input | 1 | Load pointer bits [15:8] |
| host_ld_up | input | 1 | Load pointer bits [17:16] from data bits [1:0] |
| host_din | input | 8 | Host data byte for loads |
| host_rd | input | 1 | One-cycle readback request |
| rd_data | output | 8 | Last byte read from memory |
| rd_valid | output | 1 | Pulse: rd_data updated |
| rd_busy | output | 1 | Pulse: read request refused |
| addr_q | output | 18 | Current pointer |
| full | output | 1 | Pointer wrapped since last clear/load |
| empty | output | 1 | Pointer equals zero |
| ovf | output | 1 | Sticky sample-dropped flag |
| sram_addr | output | 18 | Memory address |
| sram_dq_o | output | 8 | Write data to memory |
| sram_dq_oe | output | 1 | Drive enable for write data |
| sram_dq_i | input | 8 | Read data from memory |
| sram_ce_n | output | 1 | Chip-select, active low |
| sram_we_n | output | 1 | Write-enable, active low |
| sram_oe_n | output | 1 | Output-enable, active low |

## Verification
The hardest state to reach is the end of the address space. Filling 256 K locations with samples would take far too long. The stimulus instead uses the byte loads to park the pointer at all ones, with a full-byte upper load to show that the surplus bits are discarded. One more sample then forces the wrap, and the next sample hits the full memory and must be dropped. A readback of address zero then shows that the dropped sample did not overwrite the first byte captured. A second hard case is a sample arriving one cycle after another, while the write is in flight. A directed two-strobe burst covers it. Random operations follow, mixing captures, refused reads, readbacks, loads and clears against a model of the pointer and the memory contents.

// File: rtl/sram_cap_pkg.sv
package sram_cap_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE    = 3'd0,
    ENG_WR_LOW  = 3'd1,
    ENG_WR_HIGH = 3'd2,
    ENG_RD_ADDR = 3'd3,
    ENG_RD_SAMP = 3'd4
  } eng_state_e;

  typedef struct packed {
    logic clr;
    logic ld_lo;
    logic ld_mid;
    logic ld_up;
  } ptr_cmd_t;

endpackage

// File: rtl/cap_addr_ptr.sv
module cap_addr_ptr
  import sram_cap_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ptr_cmd_t          cmd,
  input  logic [BYTE_W-1:0] din,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr,
  output logic              full,
  output logic              load_evt,
  output logic              wrap_evt
);

  localparam int SEG_LO  = 0;
  localparam int SEG_MID = 1;
  localparam int SEG_UP  = 2;

  // Replace one byte-sized field of the pointer; bits beyond ADDR_W are lost.
  function automatic logic [ADDR_W-1:0] seg_load(
    input logic [ADDR_W-1:0] cur,
    input int                seg,
    input logic [BYTE_W-1:0] b
  );
    logic [ADDR_W-1:0] r;
    r = cur;
    for (int i = 0; i < ADDR_W; i++) begin
      if ((i / BYTE_W) == seg) r[i] = b[i % BYTE_W];
    end
    return r;
  endfunction

  // Step with carry-out; the carry marks a rollover.
  function automatic logic [ADDR_W:0] ptr_advance(input logic [ADDR_W-1:0] cur);
    return {1'b0, cur} + {{ADDR_W{1'b0}}, 1'b1};
  endfunction

  logic [ADDR_W-1:0] ptr_nxt;
  logic              full_nxt;
  logic [ADDR_W:0]   stepped;

  assign load_evt = cmd.ld_lo | cmd.ld_mid | cmd.ld_up;
  assign stepped  = ptr_advance(ptr);
  assign wrap_evt = inc & ~cmd.clr & ~load_evt & stepped[ADDR_W];

  always_comb begin
    ptr_nxt  = ptr;
    full_nxt = full;
    if (cmd.clr) begin
      ptr_nxt  = '0;
      full_nxt = 1'b0;
    end else if (cmd.ld_lo) begin
      ptr_nxt  = seg_load(ptr, SEG_LO, din);
      full_nxt = 1'b0;
    end else if (cmd.ld_mid) begin
      ptr_nxt  = seg_load(ptr, SEG_MID, din);
      full_nxt = 1'b0;
    end else if (cmd.ld_up) begin
      ptr_nxt  = seg_load(ptr, SEG_UP, din);
      full_nxt = 1'b0;
    end else if (inc) begin
      ptr_nxt  = stepped[ADDR_W-1:0];
      full_nxt = full | stepped[ADDR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      full <= 1'b0;
    end else begin
      ptr  <= ptr_nxt;
      full <= full_nxt;
    end
  end

endmodule

// File: rtl/cap_engine.sv
module cap_engine
  import sram_cap_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_active,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              full,
  input  logic              flag_clr,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_busy,
  output logic              ovf,
  output logic              inc,
  output logic              drop_evt
);

  eng_state_e        state, state_nxt;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              idle, start_wr, start_rd, refuse;

  assign idle     = (state == ENG_IDLE);
  assign start_wr = acq_active & smp_valid & idle & ~full;
  assign drop_evt = acq_active & smp_valid & (~idle | full);
  assign start_rd = host_rd & ~acq_active & idle;
  assign refuse   = host_rd & ~start_rd;
  assign inc      = (state == ENG_WR_HIGH) | (state == ENG_RD_SAMP);

  always_comb begin
    state_nxt = state;
    unique case (state)
      ENG_IDLE: begin
        if (start_wr)      state_nxt = ENG_WR_LOW;
        else if (start_rd) state_nxt = ENG_RD_ADDR;
      end
      ENG_WR_LOW:  state_nxt = ENG_WR_HIGH;
      ENG_WR_HIGH: state_nxt = ENG_IDLE;
      ENG_RD_ADDR: state_nxt = ENG_RD_SAMP;
      ENG_RD_SAMP: state_nxt = ENG_IDLE;
      default:     state_nxt = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      hold_addr <= '0;
      hold_data <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      rd_busy   <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      state    <= state_nxt;
      rd_valid <= (state == ENG_RD_SAMP);
      rd_busy  <= refuse;
      if (start_wr | start_rd) hold_addr <= ptr;
      if (start_wr)            hold_data <= smp_data;
      if (state == ENG_RD_SAMP) rd_data <= sram_dq_i;
      if (flag_clr)       ovf <= 1'b0;
      else if (drop_evt)  ovf <= 1'b1;
    end
  end

  assign sram_addr  = hold_addr;
  assign sram_dq_o  = hold_data;
  assign sram_dq_oe = (state == ENG_WR_LOW) | (state == ENG_WR_HIGH);
  assign sram_ce_n  = idle;
  assign sram_we_n  = (state != ENG_WR_LOW);
  assign sram_oe_n  = ~((state == ENG_RD_ADDR) | (state == ENG_RD_SAMP));

endmodule

// File: rtl/sram_capture_ctrl.sv
module sram_capture_ctrl
  import sram_cap_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_active,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              host_clr,
  input  logic              host_ld_lo,
  input  logic              host_ld_mid,
  input  logic              host_ld_up,
  input  logic [DATA_W-1:0] host_din,
  input  logic              host_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_busy,
  output logic [ADDR_W-1:0] addr_q,
  output logic              full,
  output logic              empty,
  output logic              ovf,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);

  ptr_cmd_t cmd;
  logic     ptr_inc, load_evt, wrap_evt, drop_evt, flag_clr;

  assign cmd      = '{clr: host_clr, ld_lo: host_ld_lo, ld_mid: host_ld_mid, ld_up: host_ld_up};
  assign flag_clr = host_clr | load_evt;

  cap_addr_ptr #(.ADDR_W(ADDR_W), .BYTE_W(DATA_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .din      (host_din),
    .inc      (ptr_inc),
    .ptr      (addr_q),
    .full     (full),
    .load_evt (load_evt),
    .wrap_evt (wrap_evt)
  );

  cap_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_active (acq_active),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .host_rd    (host_rd),
    .ptr        (addr_q),
    .full       (full),
    .flag_clr   (flag_clr),
    .sram_dq_i  (sram_dq_i),
    .sram_addr  (sram_addr),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rd_busy    (rd_busy),
    .ovf        (ovf),
    .inc        (ptr_inc),
    .drop_evt   (drop_evt)
  );

  assign empty = ~|addr_q;

endmodule

// File: rtl/sram_capture_ctrl_chk.sv
module sram_capture_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_clr,
  input logic              load_evt,
  input logic              ptr_inc,
  input logic              wrap_evt,
  input logic [ADDR_W-1:0] addr_q,
  input logic              full,
  input logic              empty,
  input logic              ovf,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n
);

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> (addr_q == '0) && !full && !ovf);

  p_load_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !full && !ovf);

  p_wrap_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> full && empty);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !host_clr && !load_evt && !wrap_evt) |=> (addr_q == $past(addr_q) + 1'b1));

  p_we_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n && sram_oe_n && sram_dq_oe);

  p_we_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n && !sram_ce_n && $stable(sram_addr) && $stable(sram_dq_o));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !host_clr && !load_evt) |=> ovf);

  p_rd_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> sram_we_n && !sram_dq_oe && !sram_ce_n);

  p_rd_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!sram_oe_n));

endmodule

bind sram_capture_ctrl sram_capture_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_clr   (host_clr),
  .load_evt   (load_evt),
  .ptr_inc    (ptr_inc),
  .wrap_evt   (wrap_evt),
  .addr_q     (addr_q),
  .full       (full),
  .empty      (empty),
  .ovf        (ovf),
  .rd_valid   (rd_valid),
  .sram_addr  (sram_addr),
  .sram_dq_o  (sram_dq_o),
  .sram_dq_oe (sram_dq_oe),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n)
);

// File: tb/sram_capture_ctrl_tb.sv
module sram_capture_ctrl_tb;

  localparam int AW = 18;
  localparam int DW = 8;
  localparam logic [AW-1:0] TOP_ADDR = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acq_active = 1'b0, smp_valid = 1'b0, host_rd = 1'b0;
  logic          host_clr = 1'b0, host_ld_lo = 1'b0, host_ld_mid = 1'b0, host_ld_up = 1'b0;
  logic [DW-1:0] smp_data = '0, host_din = '0, sram_dq_i = '0;
  logic [DW-1:0] rd_data, sram_dq_o;
  logic          rd_valid, rd_busy, full, empty, ovf, sram_dq_oe;
  logic          sram_ce_n, sram_we_n, sram_oe_n;
  logic [AW-1:0] addr_q, sram_addr;

  int checks = 0;
  int errors = 0;
  int oe_during_acq = 0;

  logic [DW-1:0] sram_mem [int];
  logic [DW-1:0] exp_mem  [int];
  logic [AW-1:0] m_ptr = '0;
  logic          m_full = 1'b0, m_ovf = 1'b0;

  always #4 clk = ~clk;

  sram_capture_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acq_active(acq_active), .smp_valid(smp_valid),
    .smp_data(smp_data), .host_clr(host_clr), .host_ld_lo(host_ld_lo),
    .host_ld_mid(host_ld_mid), .host_ld_up(host_ld_up), .host_din(host_din),
    .host_rd(host_rd), .rd_data(rd_data), .rd_valid(rd_valid), .rd_busy(rd_busy),
    .addr_q(addr_q), .full(full), .empty(empty), .ovf(ovf), .sram_addr(sram_addr),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  // Memory model: write at the edge that ends the low write-enable cycle.
  always @(posedge clk) begin
    if (rst_n && !sram_ce_n && !sram_we_n) sram_mem[int'(sram_addr)] = sram_dq_o;
    if (rst_n && !sram_oe_n && acq_active) oe_during_acq++;
  end
  always @(negedge clk) begin
    if (!sram_ce_n && !sram_oe_n)
      sram_dq_i <= sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : 8'h00;
    else
      sram_dq_i <= 8'hEE;
  end

  function automatic logic [DW-1:0] exp_byte(input logic [AW-1:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00;
  endfunction

  // Pointer step as the requirements describe it: roll over to zero from the top.
  function automatic logic [AW-1:0] m_next(input logic [AW-1:0] a);
    return (a == TOP_ADDR) ? '0 : a + 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " ptr"},   32'(addr_q), 32'(m_ptr));
    chk({req, " full"},  32'(full),   32'(m_full));
    chk({req, " empty"}, 32'(empty),  32'(m_ptr == '0));  // R4
    chk({req, " ovf"},   32'(ovf),    32'(m_ovf));
  endtask

  function automatic void m_advance();
    if (m_ptr == TOP_ADDR) m_full = 1'b1;
    m_ptr = m_next(m_ptr);
  endfunction

  task automatic do_sample(input logic [DW-1:0] d);
    acq_active = 1'b1;
    @(negedge clk); smp_valid = 1'b1; smp_data = d;
    @(negedge clk); smp_valid = 1'b0;
    if (m_full) begin
      chk("R6 no write when full", 32'(sram_ce_n), 32'd1);
      m_ovf = 1'b1;
    end else begin
      chk("R5 first cycle we_n",  32'(sram_we_n),  32'd0);
      chk("R5 first cycle ce_n",  32'(sram_ce_n),  32'd0);
      chk("R5 write address",     32'(sram_addr),  32'(m_ptr));
      chk("R5 write data",        32'(sram_dq_o),  32'(d));
      chk("R5 bus driven",        32'(sram_dq_oe), 32'd1);
    end
    @(negedge clk);
    if (!m_full) begin
      chk("R5 second cycle we_n", 32'(sram_we_n), 32'd1);
      chk("R5 second cycle ce_n", 32'(sram_ce_n), 32'd0);
      exp_mem[int'(m_ptr)] = d;
      m_advance();
    end
    @(negedge clk);
    chk_state("R3 after sample");
  endtask

  task automatic do_read();
    acq_active = 1'b0;
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    chk("R8 oe_n low",     32'(sram_oe_n),  32'd0);
    chk("R8 we_n high",    32'(sram_we_n),  32'd1);
    chk("R8 bus released", 32'(sram_dq_oe), 32'd0);
    chk("R8 read address", 32'(sram_addr),  32'(m_ptr));
    @(negedge clk);
    @(negedge clk);
    chk("R8 rd_valid", 32'(rd_valid), 32'd1);
    chk("R8 rd_data",  32'(rd_data),  32'(exp_byte(m_ptr)));
    m_advance();
    chk_state("R8 after read");
  endtask

  task automatic do_busy_read();
    acq_active = 1'b1;
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    chk("R7 busy pulse", 32'(rd_busy),   32'd1);
    chk("R7 no access",  32'(sram_ce_n), 32'd1);
    @(negedge clk);
    chk("R7 busy ends",  32'(rd_busy),   32'd0);
    chk("R7 no rd_valid", 32'(rd_valid), 32'd0);
    chk_state("R7 pointer kept");
  endtask

  // which: 0 low, 1 mid, 2 upper
  task automatic do_load(input int which, input logic [DW-1:0] d);
    @(negedge clk);
    host_din = d;
    host_ld_lo = (which == 0); host_ld_mid = (which == 1); host_ld_up = (which == 2);
    @(negedge clk);
    host_ld_lo = 1'b0; host_ld_mid = 1'b0; host_ld_up = 1'b0;
    case (which)
      0:       m_ptr[7:0]   = d;
      1:       m_ptr[15:8]  = d;
      default: m_ptr[17:16] = d[1:0];
    endcase
    m_full = 1'b0; m_ovf = 1'b0;
    chk_state("R2 after load");
  endtask

  task automatic do_clear();
    @(negedge clk); host_clr = 1'b1;
    @(negedge clk); host_clr = 1'b0;
    m_ptr = '0; m_full = 1'b0; m_ovf = 1'b0;
    chk_state("R1 after clear");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk_state("R9 reset");
    chk("R9 ce_n", 32'(sram_ce_n), 32'd1);
    chk("R9 we_n", 32'(sram_we_n), 32'd1);
    chk("R9 oe_n", 32'(sram_oe_n), 32'd1);
    chk("R9 rd_valid", 32'(rd_valid), 32'd0);
    chk("R9 rd_busy",  32'(rd_busy),  32'd0);

    // R3 capture a few samples, R8 read them back
    do_sample(8'h5A); do_sample(8'hC3); do_sample(8'h17);
    do_busy_read();
    do_clear();
    do_read(); do_read(); do_read();

    // R6 second strobe while the write is in flight is dropped
    acq_active = 1'b1;
    @(negedge clk); smp_valid = 1'b1; smp_data = 8'hA1;
    @(negedge clk); smp_data = 8'hA2;
    @(negedge clk); smp_valid = 1'b0;
    @(negedge clk);
    exp_mem[int'(m_ptr)] = 8'hA1; m_advance(); m_ovf = 1'b1;
    chk_state("R6 busy drop");

    // R6 strobe with acquisition off is ignored
    acq_active = 1'b0;
    @(negedge clk); smp_valid = 1'b1; smp_data = 8'h99;
    @(negedge clk); smp_valid = 1'b0;
    chk("R6 ignored no access", 32'(sram_ce_n), 32'd1);
    @(negedge clk); @(negedge clk);
    chk_state("R6 ignored");

    // R2 priority: low and mid together, only low applies
    @(negedge clk); host_din = 8'h3C; host_ld_lo = 1'b1; host_ld_mid = 1'b1;
    @(negedge clk); host_ld_lo = 1'b0; host_ld_mid = 1'b0;
    m_ptr[7:0] = 8'h3C; m_ovf = 1'b0; m_full = 1'b0;
    chk_state("R2 priority");

    // Park at the top; upper load ignores surplus bits
    do_load(0, 8'hFF); do_load(1, 8'hFF); do_load(2, 8'hFF);
    chk("R2 top address", 32'(addr_q), 32'(TOP_ADDR));
    do_sample(8'h66);                 // R3 wrap sets full
    chk("R3 full after wrap", 32'(full), 32'd1);
    do_sample(8'h77);                 // R6 dropped when full
    chk("R6 ovf when full", 32'(ovf), 32'd1);
    do_read();                        // address 0 keeps the earlier byte
    // R1 clear beats a simultaneous load
    @(negedge clk); host_clr = 1'b1; host_ld_lo = 1'b1; host_din = 8'h55;
    @(negedge clk); host_clr = 1'b0; host_ld_lo = 1'b0;
    m_ptr = '0; m_full = 1'b0; m_ovf = 1'b0;
    chk_state("R1 clear priority");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op <= 3)      do_sample(8'($urandom));
      else if (op <= 5) do_read();
      else if (op == 6) do_busy_read();
      else if (op <= 8) do_load(int'($urandom_range(0, 2)), 8'($urandom));
      else              do_clear();
    end

    chk("R7 oe_n never low during acquisition", 32'(oe_during_acq), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule